// File: doc/BRIEF.md
# Stride Transpose Reorder Buffer

This block sits in front of a wide-path FFT. Every clock it can take a word of P complex samples from a frame of N = P×P samples that arrives in natural order. It hands the frame back as P groups of P samples. Group k gathers every P-th sample starting at index k, which is exactly the set the k-th first-stage butterfly consumes. In effect the frame is treated as a P×P matrix and transposed.

There are two storage banks. A writer state machine fills one bank while a reader state machine drains the other, so back-to-back frames flow with no stall. The cost is one frame of latency plus one registered output cycle.

Writer states: `WR_IDLE` waits for a word carrying the frame-start flag. `WR_IDLE -> WR_FILL` occurs on a valid word with `in_sof`. `WR_FILL -> WR_FILL` occurs on each further valid word, and a valid word with `in_sof` restarts the row count. `WR_FILL -> WR_IDLE` occurs when row P-1 is written; that is the frame end, and the write bank flips. Reader states: `RD_IDLE -> RD_DRAIN` occurs at a frame end. `RD_DRAIN -> RD_DRAIN` steps the column. `RD_DRAIN -> RD_IDLE` occurs after column P-1, unless a new frame end restarts the drain at column 0 in the same cycle.

Top module: `stride_transpose_buf`

## Requirements
- R1: After reset, `out_valid` is 0 and stays 0 until a complete frame has been written.
- R2: Input word t of a frame (t = 0..P-1) holds samples tP+j, where sample j sits at `in_data[j*2CW +: 2CW]`, with the real part in the upper CW bits and the imaginary part in the lower CW bits.
- R3: Output group k holds sample k+mP at `out_data[m*2CW +: 2CW]`, for m = 0..P-1, with the same real/imaginary packing.
- R4: The groups of a frame appear on P consecutive cycles in the order k = 0,1,..,P-1, and `out_group` carries k.
- R5: Group 0 appears one cycle after the clock edge that captures the frame's last word. Counted from the cycle in which that word is presented, it is two edges later.
- R6: Frames presented back to back produce back-to-back output groups, with the banks alternating and no stall or gap.
- R7: A valid word without `in_sof` while no frame is being filled is dropped and produces no output.
- R8: A valid word with `in_sof` in the middle of a frame discards the partial frame and starts a new frame at row 0.
- R9: Cycles with `in_valid` low inside a frame leave the row count unchanged, so each word is stored by its count, not by its arrival cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_sof | input | 1 | Word is row 0 of a new frame |
| in_data | input | P*2*CW | P consecutive complex samples |
| out_valid | output | 1 | Output group present |
| out_group | output | $clog2(P) | Index k of the group on `out_data` |
| out_data | output | P*2*CW | Samples k, k+P, ..., k+(P-1)P |

## Verification
The bench first sends frames back to back, so the drain of one bank and the fill of the other overlap. A design that mixed up banks or restarted the drain late would corrupt data or leave a gap in the groups. It also sends frames with idle gaps inside them, which catches a row counter that advances on cycles without valid data. Stray words without a frame start while idle must produce no output; a design that accepted them would emit a spurious frame. A frame start in the middle of a frame must discard the partial rows; a design that kept counting would emit a shifted, mixed frame. Each group is also checked against its exact cycle, which exposes any added or missing pipeline register.

// File: rtl/tpb_pkg.sv
package tpb_pkg;
    localparam int COMP_W = 8;

    typedef enum logic {
        WR_IDLE = 1'b0,
        WR_FILL = 1'b1
    } wr_state_e;

    typedef enum logic {
        RD_IDLE  = 1'b0,
        RD_DRAIN = 1'b1
    } rd_state_e;
endpackage

// File: rtl/tpb_wr_ctrl.sv
module tpb_wr_ctrl #(
    parameter int P = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_sof,
    output logic                 we,
    output logic                 wr_bank,
    output logic [$clog2(P)-1:0] wr_row,
    output logic                 frame_done
);
    import tpb_pkg::*;
    localparam int RW = $clog2(P);

    wr_state_e     state_q;
    logic [RW-1:0] row_q;
    logic          bank_q;
    logic          accept;
    logic [RW-1:0] row_use;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WR_IDLE;
            row_q   <= '0;
            bank_q  <= 1'b0;
        end else if (frame_done) begin
            state_q <= WR_IDLE;
            row_q   <= '0;
            bank_q  <= ~bank_q;
        end else if (accept) begin
            state_q <= WR_FILL;
            row_q   <= RW'(row_use + 1'b1);
        end
    end

    always_comb begin
        unique case (state_q)
            WR_IDLE: accept = in_valid && in_sof;
            WR_FILL: accept = in_valid;
            default: accept = 1'b0;
        endcase
        row_use    = in_sof ? '0 : row_q;
        we         = accept;
        wr_row     = row_use;
        wr_bank    = bank_q;
        frame_done = accept && (row_use == RW'(P - 1));
    end

    // R6: each completed frame moves the writer to the other bank
    p_bank_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> (bank_q != $past(bank_q)));
endmodule

// File: rtl/tpb_rd_ctrl.sv
module tpb_rd_ctrl #(
    parameter int P = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_done,
    input  logic                 done_bank,
    output logic                 rd_en,
    output logic                 rd_bank,
    output logic [$clog2(P)-1:0] rd_col
);
    import tpb_pkg::*;
    localparam int RW = $clog2(P);

    rd_state_e     state_q;
    logic [RW-1:0] col_q;
    logic          bank_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
            col_q   <= '0;
            bank_q  <= 1'b0;
        end else if (frame_done) begin
            state_q <= RD_DRAIN;
            col_q   <= '0;
            bank_q  <= done_bank;
        end else begin
            unique case (state_q)
                RD_IDLE: col_q <= '0;
                RD_DRAIN: begin
                    if (col_q == RW'(P - 1)) begin
                        state_q <= RD_IDLE;
                        col_q   <= '0;
                    end else begin
                        col_q <= RW'(col_q + 1'b1);
                    end
                end
                default: state_q <= RD_IDLE;
            endcase
        end
    end

    always_comb begin
        rd_en   = (state_q == RD_DRAIN);
        rd_bank = bank_q;
        rd_col  = col_q;
    end
endmodule

// File: rtl/tpb_bank_mem.sv
module tpb_bank_mem #(
    parameter int P  = 4,
    parameter int SW = 16
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic                 wr_bank,
    input  logic [$clog2(P)-1:0] wr_row,
    input  logic [P*SW-1:0]      wr_data,
    input  logic                 rd_bank,
    input  logic [$clog2(P)-1:0] rd_col,
    output logic [P*SW-1:0]      rd_data
);
    logic [SW-1:0] mem_q [2][P][P];

    for (genvar j = 0; j < P; j++) begin : g_col
        always_ff @(posedge clk) begin
            if (we) mem_q[wr_bank][wr_row][j] <= wr_data[j*SW +: SW];
        end
        // output lane j takes row j of the selected column
        assign rd_data[j*SW +: SW] = mem_q[rd_bank][j][rd_col];
    end
endmodule

// File: rtl/stride_transpose_buf.sv
module stride_transpose_buf #(
    parameter int P  = 4,
    parameter int CW = tpb_pkg::COMP_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   in_sof,
    input  logic [P*2*CW-1:0]      in_data,
    output logic                   out_valid,
    output logic [$clog2(P)-1:0]   out_group,
    output logic [P*2*CW-1:0]      out_data
);
    localparam int SW = 2 * CW;
    localparam int RW = $clog2(P);

    logic          we, wr_bank, frame_done;
    logic [RW-1:0] wr_row;
    logic          rd_en, rd_bank;
    logic [RW-1:0] rd_col;
    logic [P*SW-1:0] rd_data;

    tpb_wr_ctrl #(.P(P)) wr_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .we(we), .wr_bank(wr_bank), .wr_row(wr_row), .frame_done(frame_done)
    );

    tpb_rd_ctrl #(.P(P)) rd_i (
        .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .done_bank(wr_bank),
        .rd_en(rd_en), .rd_bank(rd_bank), .rd_col(rd_col)
    );

    tpb_bank_mem #(.P(P), .SW(SW)) mem_i (
        .clk(clk), .we(we), .wr_bank(wr_bank), .wr_row(wr_row), .wr_data(in_data),
        .rd_bank(rd_bank), .rd_col(rd_col), .rd_data(rd_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_group <= '0;
        end else begin
            out_valid <= rd_en;
            out_group <= rd_col;
        end
    end

    always_ff @(posedge clk) begin
        out_data <= rd_data;
    end

    // R4: groups of a frame follow each other without gaps, index rising by one
    p_group_seq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_group != RW'(P - 1)) |=>
            (out_valid && out_group == RW'($past(out_group) + 1'b1)));

    // R5: group 0 leaves two edges after the cycle presenting the last word
    p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> ##2 (out_valid && out_group == '0));

    // R6: the writer never targets the bank being drained
    p_bank_clash_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && we) |-> (rd_bank != wr_bank));

    // R1: no output without a completed frame before it
    p_first_out_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> ($past(rd_en) && out_group == '0));
endmodule

// File: tb/stride_transpose_buf_tb_top.sv
module stride_transpose_buf_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int P  = 4;
    localparam int CW = 8;
    localparam int SW = 2 * CW;
    localparam int GW = $clog2(P);
    localparam int NSCN = 6;
    // scenario vector: {seed[7:0], gap[7:0]}; gap>0 puts idle cycles inside the frame (R9)
    localparam logic [15:0] SCN [NSCN] = '{
        16'h1100, 16'h2A00, 16'h5300, 16'h7C02, 16'h9501, 16'hE600
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_sof = 1'b0;
    logic [P*SW-1:0] in_data = '0;
    logic out_valid;
    logic [GW-1:0] out_group;
    logic [P*SW-1:0] out_data;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int grp_cnt = 0;
    bit done_flag = 1'b0;
    int exp_seed [$];
    int exp_cyc [$];
    string exp_tag [$];

    stride_transpose_buf #(.P(P), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_data(in_data), .out_valid(out_valid), .out_group(out_group),
        .out_data(out_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // sample i of a frame: real in upper byte, imaginary in lower byte (R2)
    function automatic logic [SW-1:0] smp(int seed, int i);
        return {CW'(seed + i), CW'(seed ^ (i * 5))};
    endfunction

    function automatic logic [P*SW-1:0] exp_group(int seed, int k);
        logic [P*SW-1:0] v;
        for (int m = 0; m < P; m++) v[m*SW +: SW] = smp(seed, k + m * P);
        return v;
    endfunction

    task automatic check(bit ok, string tag, logic [P*SW-1:0] act, logic [P*SW-1:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic drive(bit v, bit s, int seed, int row);
        @(negedge clk);
        in_valid = v;
        in_sof = s;
        for (int j = 0; j < P; j++) in_data[j*SW +: SW] = smp(seed, row * P + j);
    endtask

    task automatic send_frame(int seed, int gap, string tag);
        for (int r = 0; r < P; r++) begin
            drive(1'b1, r == 0, seed, r);
            if (r == P - 1) begin
                exp_seed.push_back(seed);
                exp_cyc.push_back(cyc + 2);
                exp_tag.push_back(tag);
            end else begin
                for (int g = 0; g < gap; g++) drive(1'b0, 1'b0, 8'hEE, 0);
            end
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 0, 0);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // output monitor, sampling away from the active edge
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_seed.size() == 0) begin
                check(1'b0, "R7/R8 unexpected output group", out_data, '0);
            end else begin
                check(out_data == exp_group(exp_seed[0], grp_cnt),
                      {"R2 R3 data ", exp_tag[0]}, out_data, exp_group(exp_seed[0], grp_cnt));
                check(out_group == GW'(grp_cnt), "R4 group index",
                      (P*SW)'(out_group), (P*SW)'(grp_cnt));
                check(cyc == exp_cyc[0] + grp_cnt, {"R5 R6 timing ", exp_tag[0]},
                      (P*SW)'(cyc), (P*SW)'(exp_cyc[0] + grp_cnt));
                grp_cnt++;
                if (grp_cnt == P) begin
                    grp_cnt = 0;
                    void'(exp_seed.pop_front());
                    void'(exp_cyc.pop_front());
                    void'(exp_tag.pop_front());
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid in reset", (P*SW)'(out_valid), '0);
        rst_n = 1'b1;
        idle(3);
        check(out_valid == 1'b0, "R1 out_valid after reset", (P*SW)'(out_valid), '0);

        // table walk: back-to-back frames (R6) and frames with gaps (R9)
        for (int s = 0; s < NSCN; s++)
            send_frame(int'(SCN[s][15:8]), int'(SCN[s][7:0]),
                       SCN[s][7:0] != 0 ? "R9 gapped" : "R6 streamed");
        idle(2 * P + 4);
        check(exp_seed.size() == 0, "R6 all table frames drained",
              (P*SW)'(exp_seed.size()), '0);

        // R7: stray words without frame start while idle
        for (int i = 0; i < P + 1; i++) drive(1'b1, 1'b0, 8'h33, i % P);
        idle(P + 4);
        check(out_valid == 1'b0, "R7 stray words dropped", (P*SW)'(out_valid), '0);

        // R8: frame start in mid-frame discards partial rows
        drive(1'b1, 1'b1, 8'h44, 0);
        drive(1'b1, 1'b0, 8'h44, 1);
        send_frame(8'hA7, 0, "R8 restart");
        idle(2 * P + 4);

        // R9: long gap inside one frame
        send_frame(8'h3D, 5, "R9 long gap");
        idle(2 * P + 4);
        check(exp_seed.size() == 0, "R8 R9 frames drained",
              (P*SW)'(exp_seed.size()), '0);
        finish_run();
    end
endmodule